// File: doc/BRIEF.md
# Sixteen-Line Edge-Interrupt GPIO Port

This block is a 16-line general-purpose I/O port controlled through a small 16-bit register bus. Software decides per line whether it is an input or an output. Output lines take their level from an output register. Input lines are resynchronised to the port clock and can set a status bit on a chosen edge. The status bits share one interrupt line.

The interrupt stays high while any status bit is set. Software clears status bits by writing ones to them. A pin-enable register gates what the input register reads back. The bus accepts only full 16-bit accesses. A narrow access is flagged and has no effect, and unmapped offsets read as zero.

Register byte offsets: 0x00 input data (read-only), 0x04 output data, 0x08 direction, 0x0C edge select, 0x10 interrupt mask, 0x14 interrupt status, 0x18 pin-enable.

Top module: `gpio16_edge_port`

## Requirements
- R1: After reset, the output, direction, edge-select, mask and pin-enable registers read 0xFFFF. The status register and the input register read 0x0000. `irq` is low and `pin_out` is 0x0000.
- R2: A read of offset 0x00 returns the synchronised `pin_in` value ANDed with the pin-enable register (offset 0x18). A `pin_in` value sampled at a rising edge becomes readable after the next rising edge. Writes to offset 0x00 change nothing.
- R3: A direction bit of 1 makes its line an input and 0 makes it an output. A write to the output register (0x04) copies the new value onto `pin_out` for output lines only, from the next cycle. `pin_out` changes only after a write to the output or direction register.
- R4: On a write to the direction register (0x08), each line whose direction bit changes shows, on `pin_out`, its stored output bit ANDed with the inverse of the new direction bit. Lines whose direction is unchanged keep their `pin_out` level.
- R5: An edge-select bit of 1 selects rising edges on that line and 0 selects falling edges. A selected edge on an unmasked input line sets that line's status bit. If the `pin_in` change is first sampled at rising edge k, the status bit is visible after edge k+2.
- R6: A mask bit of 1 stops its line from setting status. A line whose direction bit is 0 never sets status.
- R7: A write to the status register (0x14) clears every status bit written as 1 and leaves the other bits unchanged. An edge that sets a bit in the same cycle as a clear of that bit wins, so the bit stays set.
- R8: `irq` is high exactly when at least one status bit is set. `irq` stays high after a partial clear and drops only once a clear leaves the status register at zero.
- R9: An access with `bus_wide` low raises `bus_err` in the same cycle, returns zero read data and changes no register.
- R10: Reads of unmapped offsets (anything other than the seven listed) return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 16-bit access; 0 = narrower access (rejected) |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational, valid in the access cycle |
| bus_err | output | 1 | High during a rejected (narrow) access |
| pin_in | input | 16 | Asynchronous input pin levels |
| pin_out | output | 16 | Driven output pin levels |
| irq | output | 1 | Shared interrupt, high while any status bit is set |

## Verification
Each result is due at its own cycle:
- Read data and `bus_err` are due in the access cycle itself.
- Register and `pin_out` updates from a write are due one edge after it.
- An input change is readable after two edges.
- An input change reaches status and `irq` after three edges.

The bench model holds a four-deep history queue of sampled pin values and updates its registers at each rising edge, so it produces each of those latencies from its own timeline. Outputs are compared against it three nanoseconds after every rising edge, well before the next one. Directed reads are taken only after enough idle cycles that the latency cannot hide an error. The bench also lines up a clear write and a new edge on the same status bit, to exercise the R7 priority.

// File: rtl/gpio16_edge_port.sv
module gpio16_edge_port #(
  parameter int W  = 16,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic          bus_wide,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  output logic          bus_err,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pin_out,
  output logic          irq
);

  localparam logic [AW-1:0] A_IN   = AW'(5'h00);
  localparam logic [AW-1:0] A_OUT  = AW'(5'h04);
  localparam logic [AW-1:0] A_DIR  = AW'(5'h08);
  localparam logic [AW-1:0] A_EDGE = AW'(5'h0C);
  localparam logic [AW-1:0] A_MASK = AW'(5'h10);
  localparam logic [AW-1:0] A_STAT = AW'(5'h14);
  localparam logic [AW-1:0] A_PEN  = AW'(5'h18);
  localparam logic [W-1:0]  ONES   = {W{1'b1}};

  logic [W-1:0] out_q, dir_q, edge_q, mask_q, pen_q, stat_q, pin_q;
  logic [W-1:0] sy1_q, sy2_q, old_q;
  logic [W-1:0] hit, chg;
  logic acc, wr;
  logic wr_out, wr_dir, wr_edge, wr_mask, wr_stat, wr_pen;

  assign acc     = bus_sel & bus_wide;
  assign wr      = acc & bus_we;
  assign wr_out  = wr & (bus_addr == A_OUT);
  assign wr_dir  = wr & (bus_addr == A_DIR);
  assign wr_edge = wr & (bus_addr == A_EDGE);
  assign wr_mask = wr & (bus_addr == A_MASK);
  assign wr_stat = wr & (bus_addr == A_STAT);
  assign wr_pen  = wr & (bus_addr == A_PEN);
  assign bus_err = bus_sel & ~bus_wide;

  assign hit = dir_q & ~mask_q &
               ((edge_q & sy2_q & ~old_q) | (~edge_q & ~sy2_q & old_q));
  assign chg = dir_q ^ bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1_q <= '0;
      sy2_q <= '0;
      old_q <= '0;
    end else begin
      sy1_q <= pin_in;
      sy2_q <= sy1_q;
      old_q <= sy2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= ONES;
      dir_q  <= ONES;
      edge_q <= ONES;
      mask_q <= ONES;
      pen_q  <= ONES;
    end else begin
      if (wr_out)  out_q  <= bus_wdata;
      if (wr_dir)  dir_q  <= bus_wdata;
      if (wr_edge) edge_q <= bus_wdata;
      if (wr_mask) mask_q <= bus_wdata;
      if (wr_pen)  pen_q  <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~(wr_stat ? bus_wdata : '0)) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pin_q <= '0;
    else if (wr_out)
      pin_q <= (pin_q & dir_q) | (bus_wdata & ~dir_q);
    else if (wr_dir)
      pin_q <= (pin_q & ~chg) | (out_q & ~bus_wdata & chg);
  end

  assign pin_out = pin_q;
  assign irq     = |stat_q;

  always_comb begin
    bus_rdata = '0;
    if (acc && !bus_we) begin
      case (bus_addr)
        A_IN:    bus_rdata = sy2_q & pen_q;
        A_OUT:   bus_rdata = out_q;
        A_DIR:   bus_rdata = dir_q;
        A_EDGE:  bus_rdata = edge_q;
        A_MASK:  bus_rdata = mask_q;
        A_STAT:  bus_rdata = stat_q;
        A_PEN:   bus_rdata = pen_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  assert_pin_only_on_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_q != $past(pin_q)) |-> $past(wr_out | wr_dir));

  assert_no_masked_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> ((stat_q & ~$past(stat_q) & ($past(mask_q) | ~$past(dir_q))) == '0));

  assert_irq_fall_needs_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(wr_stat));

  assert_narrow_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && !bus_wide) |=>
      ($stable(out_q) && $stable(dir_q) && $stable(edge_q) && $stable(mask_q) && $stable(pen_q)));

  assert_narrow_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_rdata == '0));

endmodule

// File: tb/gpio16_edge_port_tb_top.sv
module gpio16_edge_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0, bus_wide = 1'b1;
  logic [4:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata, pin_in = '0, pin_out;
  logic bus_err, irq;

  always #5 clk = ~clk;

  gpio16_edge_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_wide(bus_wide),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .pin_in(pin_in), .pin_out(pin_out), .irq(irq));

  int total = 0, bad = 0;
  bit finished = 0;
  string cur_req = "R1";

  logic [15:0] m_out, m_dir, m_edge, m_mask, m_pen, m_stat, m_pin;
  logic [15:0] hist [$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_out = 16'hFFFF; m_dir = 16'hFFFF; m_edge = 16'hFFFF; m_mask = 16'hFFFF;
      m_pen = 16'hFFFF; m_stat = 16'h0; m_pin = 16'h0;
      hist = {16'h0, 16'h0, 16'h0, 16'h0};
    end else begin
      logic [15:0] rise, fall, hitv, clr, od, cg;
      hist.push_front(pin_in);
      void'(hist.pop_back());
      rise = hist[2] & ~hist[3];
      fall = ~hist[2] & hist[3];
      hitv = m_dir & ~m_mask & ((m_edge & rise) | (~m_edge & fall));
      clr = 16'h0;
      od = m_dir;
      if (bus_sel && bus_we && bus_wide) begin
        case (bus_addr)
          5'h04: begin
            for (int i = 0; i < 16; i++) if (!od[i]) m_pin[i] = bus_wdata[i];
            m_out = bus_wdata;
          end
          5'h08: begin
            cg = od ^ bus_wdata;
            for (int i = 0; i < 16; i++) if (cg[i]) m_pin[i] = m_out[i] & ~bus_wdata[i];
            m_dir = bus_wdata;
          end
          5'h0C: m_edge = bus_wdata;
          5'h10: m_mask = bus_wdata;
          5'h14: clr = bus_wdata;
          5'h18: m_pen = bus_wdata;
          default: ;
        endcase
      end
      m_stat = (m_stat & ~clr) | hitv;
    end
  end

  function automatic logic [15:0] model_read();
    if (!(bus_sel && bus_wide && !bus_we)) return 16'h0;
    case (bus_addr)
      5'h00: return hist[1] & m_pen;
      5'h04: return m_out;
      5'h08: return m_dir;
      5'h0C: return m_edge;
      5'h10: return m_mask;
      5'h14: return m_stat;
      5'h18: return m_pen;
      default: return 16'h0;
    endcase
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk({cur_req, " rdata"}, bus_rdata, model_read());
    chk({cur_req, " irq"}, {15'h0, irq}, {15'h0, (m_stat != 0)});
    chk({cur_req, " pin_out"}, pin_out, m_pin);
    chk({cur_req, " bus_err"}, {15'h0, bus_err}, {15'h0, bus_sel & ~bus_wide});
  endtask

  task automatic step();
    @(posedge clk);
    #3;
    compare();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic bwr(logic [4:0] a, logic [15:0] d, logic wide = 1'b1);
    bus_sel = 1; bus_we = 1; bus_wide = wide; bus_addr = a; bus_wdata = d;
    step();
    bus_sel = 0; bus_we = 0; bus_wide = 1;
  endtask

  task automatic brd(logic [4:0] a, output logic [15:0] v, input logic wide = 1'b1);
    bus_sel = 1; bus_we = 0; bus_wide = wide; bus_addr = a;
    #1 v = bus_rdata;
    step();
    bus_sel = 0; bus_wide = 1;
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(posedge clk);
    #3 rst_n = 1;
    step();
    cur_req = "R1";
    chk("R1 irq", {15'h0, irq}, 16'h0);
    chk("R1 pin_out", pin_out, 16'h0);
    brd(5'h04, v); chk("R1 out", v, 16'hFFFF);
    brd(5'h08, v); chk("R1 dir", v, 16'hFFFF);
    brd(5'h0C, v); chk("R1 edge", v, 16'hFFFF);
    brd(5'h10, v); chk("R1 mask", v, 16'hFFFF);
    brd(5'h18, v); chk("R1 pen", v, 16'hFFFF);
    brd(5'h14, v); chk("R1 stat", v, 16'h0);
    brd(5'h00, v); chk("R1 input", v, 16'h0);

    cur_req = "R2";
    pin_in = 16'hA5A5; idle(4);
    brd(5'h00, v); chk("R2 input", v, 16'hA5A5);
    bwr(5'h18, 16'h00FF);
    brd(5'h00, v); chk("R2 gated", v, 16'h00A5);
    bwr(5'h00, 16'h0000);
    brd(5'h00, v); chk("R2 ro", v, 16'h00A5);
    bwr(5'h18, 16'hFFFF);

    cur_req = "R3";
    bwr(5'h08, 16'h00FF); chk("R4 to-output", pin_out, 16'hFF00);
    bwr(5'h04, 16'h1234); chk("R3 out write", pin_out, 16'h1200);
    idle(2); chk("R3 hold", pin_out, 16'h1200);
    cur_req = "R4";
    bwr(5'h08, 16'hFFFF); chk("R4 to-input", pin_out, 16'h0000);
    bwr(5'h08, 16'h0F0F); chk("R4 mixed", pin_out, 16'h1030);

    cur_req = "R5";
    bwr(5'h08, 16'hFFFF);
    pin_in = 16'h0000; idle(4);
    bwr(5'h14, 16'hFFFF);
    bwr(5'h0C, 16'h000F);
    bwr(5'h10, 16'h0000);
    pin_in = 16'h0003; step(); step();
    brd(5'h14, v); chk("R5 not yet", v, 16'h0000);
    step();
    brd(5'h14, v); chk("R5 rising", v, 16'h0003);
    chk("R8 irq high", {15'h0, irq}, 16'h1);
    pin_in = 16'h0000; idle(4);
    brd(5'h14, v); chk("R5 fall ignored", v, 16'h0003);
    pin_in = 16'h0300; idle(4);
    brd(5'h14, v); chk("R5 rise ignored", v, 16'h0003);
    pin_in = 16'h0000; idle(4);
    brd(5'h14, v); chk("R5 falling", v, 16'h0303);

    cur_req = "R6";
    bwr(5'h14, 16'hFFFF);
    chk("R8 irq low", {15'h0, irq}, 16'h0);
    bwr(5'h10, 16'h0100);
    pin_in = 16'h0300; idle(3); pin_in = 16'h0000; idle(4);
    brd(5'h14, v); chk("R6 masked", v, 16'h0200);
    bwr(5'h14, 16'hFFFF);
    bwr(5'h08, 16'hFDFF);
    pin_in = 16'h0200; idle(3); pin_in = 16'h0000; idle(4);
    brd(5'h14, v); chk("R6 output line", v, 16'h0000);
    bwr(5'h08, 16'hFFFF);
    bwr(5'h10, 16'h0000);

    cur_req = "R7";
    pin_in = 16'h0003; idle(4);
    bwr(5'h14, 16'h0001);
    brd(5'h14, v); chk("R7 partial", v, 16'h0002);
    chk("R8 still high", {15'h0, irq}, 16'h1);
    bwr(5'h14, 16'h0002);
    chk("R8 dropped", {15'h0, irq}, 16'h0);
    pin_in = 16'h0000; idle(4);
    pin_in = 16'h0001; step(); step();
    bwr(5'h14, 16'h0001);
    brd(5'h14, v); chk("R7 set wins", v, 16'h0001);
    bwr(5'h14, 16'hFFFF);

    cur_req = "R9";
    bus_sel = 1; bus_we = 1; bus_wide = 0; bus_addr = 5'h08; bus_wdata = 16'h0000;
    #1 chk("R9 err", {15'h0, bus_err}, 16'h1);
    step(); bus_sel = 0; bus_we = 0; bus_wide = 1;
    brd(5'h08, v); chk("R9 no write", v, 16'hFFFF);
    brd(5'h04, v, 1'b0); chk("R9 narrow read", v, 16'h0000);

    cur_req = "R10";
    bwr(5'h1C, 16'h5555);
    brd(5'h1C, v); chk("R10 unmapped", v, 16'h0000);
    brd(5'h02, v); chk("R10 odd", v, 16'h0000);
    brd(5'h10, v); chk("R10 mask kept", v, 16'h0000);
    idle(3);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule